// File: doc/BRIEF.md
# Multithreaded In-Order Commit Selector

This block is the retirement arbiter of a simultaneous-multithreading core. Each thread shows a short window of its reorder-buffer head: an entry count and, for each entry, a completed flag, a store flag, a speculative flag and a sequence number. In one cycle the block walks these windows in program order inside each thread. It retires up to `COMMIT_W` instructions, squashes completed leftover mis-speculated entries, and reports why commit stopped and which thread is blamed.

Two selection policies exist. The oldest-first policy merges the threads by sequence number. The round-robin policy looks only at the thread named by an internal pointer, which steps to the next thread after every cycle spent in that policy. The results are registered and appear one clock after the inputs that produced them.

Top module: `commit_sel`

## Requirements
- R1: With `policy_rr`=0, the next entry examined is the one with the smallest sequence number among the next unexamined entries of threads that still have entries. On a tie the lower thread number wins.
- R2: With `policy_rr`=1, only the thread named by the round-robin pointer is examined. The pointer is 0 after reset. It steps to the next thread (modulo `NUM_THR`) after every cycle with `policy_rr`=1, and holds when `policy_rr`=0.
- R3: An entry is eligible only if its completed bit is 1. A completed store (store bit 1) is ineligible while `sb_full`=1. That case sets the cause to store-buffer (code 3) if no cause has been set yet. An entry that is not completed sets no cause.
- R4: An eligible entry whose speculative bit is 1 is squashed (its `squash_mask` bit is set) rather than retired, and it does not add to `retired_cnt`.
- R5: When the number retired reaches `COMMIT_W`, examination stops. The cause is bandwidth (code 1) and the blame goes to the thread of the last retired entry.
- R6: When an eligible entry is the last one left to examine, the cause is no-instruction (code 2) and the blame goes to that entry's thread.
- R7: An ineligible entry blames its thread, and the rest of that thread's window is skipped for the cycle. Other threads are still examined.
- R8: If no cause was recorded, the cause is bandwidth when `retired_cnt` equals `COMMIT_W` and no-instruction otherwise, with the blame on thread 0.
- R9: Outputs are registered: the results for the inputs present at a rising edge appear after that edge. Reset clears the masks, `retired_cnt`, the cause (code 0) and the blame, and returns the round-robin pointer to thread 0.
- R10: Within each thread, the set bits of `retire_mask | squash_mask` form a prefix of the window, starting at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_rr | input | 1 | 0 = oldest-first, 1 = round-robin |
| sb_full | input | 1 | Store buffer has no free entry |
| hd_cnt | input | NUM_THR*CW | Valid entry count per thread, thread t at [t*CW +: CW] |
| hd_done | input | NUM_THR*HEAD_D | Completed bit, entry e of thread t at bit t*HEAD_D+e |
| hd_store | input | NUM_THR*HEAD_D | Store bit, same layout |
| hd_spec | input | NUM_THR*HEAD_D | Mis-speculated bit, same layout |
| hd_seq | input | NUM_THR*HEAD_D*SEQ_W | Sequence numbers, entry slot k at [k*SEQ_W +: SEQ_W] |
| retire_mask | output | NUM_THR*HEAD_D | Entries retired in the cycle |
| squash_mask | output | NUM_THR*HEAD_D | Entries squashed in the cycle |
| retired_cnt | output | MW | Number of retired entries |
| end_cause | output | 3 | 0 none, 1 bandwidth, 2 no-instruction, 3 store-buffer, 4 barrier, 5 unit, 6 data miss |
| blame_tid | output | TW | Thread blamed for the stop |

## Verification
Every result (both masks, the count, the cause and the blame) is due at the first rising edge after the inputs are driven. The bench drives the inputs on a falling edge and compares on the next falling edge. The round-robin pointer moves at the same edge that captures a round-robin result, so its effect is checked on the following vector. Reset is checked by sampling the outputs while reset is held, and then by confirming that the first round-robin vector after release selects thread 0.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_BW    = 3'd1,
    CZ_EMPTY = 3'd2,
    CZ_SBUF  = 3'd3,
    CZ_MBAR  = 3'd4,
    CZ_FU    = 3'd5,
    CZ_DMISS = 3'd6
  } cause_e;
endpackage

// File: rtl/cmt_elig.sv
module cmt_elig #(
  parameter int NE = 16
) (
  input  logic          sb_full,
  input  logic [NE-1:0] done_i,
  input  logic [NE-1:0] store_i,
  output logic [NE-1:0] ok_o,
  output logic [NE-1:0] stall_o
);
  for (genvar k = 0; k < NE; k++) begin : g_ent
    assign stall_o[k] = done_i[k] && store_i[k] && sb_full;
    assign ok_o[k]    = done_i[k] && !(store_i[k] && sb_full);
  end
endmodule

// File: rtl/cmt_rr_ptr.sv
module cmt_rr_ptr #(
  parameter int NUM_THR = 4,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [TW-1:0] ptr
);
  localparam logic [TW-1:0] LAST = TW'(NUM_THR - 1);
  logic [TW-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (adv) ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

  // R2: every round-robin cycle moves the pointer
  a_r2_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr != $past(ptr));
endmodule

// File: rtl/cmt_pick.sv
module cmt_pick
  import cmt_pkg::*;
#(
  parameter int NUM_THR  = 4,
  parameter int HEAD_D   = 4,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W    = 16,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CW = $clog2(HEAD_D + 1),
  localparam int MW = $clog2(COMMIT_W + 1),
  localparam int NE = NUM_THR * HEAD_D
) (
  input  logic                policy_rr,
  input  logic [TW-1:0]       rr_ptr,
  input  logic [NUM_THR*CW-1:0] cnt_i,
  input  logic [NE-1:0]       ok_i,
  input  logic [NE-1:0]       stall_i,
  input  logic [NE-1:0]       spec_i,
  input  logic [NE*SEQ_W-1:0] seq_i,
  output logic [NE-1:0]       ret_o,
  output logic [NE-1:0]       sq_o,
  output logic [MW-1:0]       cmt_o,
  output cause_e              cause_o,
  output logic [TW-1:0]       blame_o
);
  localparam int NW    = $clog2(NE + 1);
  localparam int STEPS = NE + NUM_THR;
  localparam logic [MW-1:0] W_C = MW'(COMMIT_W);

  logic [CW-1:0]    cnt  [NUM_THR];
  logic [CW-1:0]    idx  [NUM_THR];
  logic [NUM_THR-1:0] fin;
  logic [NW-1:0]    left;
  logic             stop, have;
  logic [TW-1:0]    pick;
  logic [SEQ_W-1:0] best, cand;
  int               e;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_cnt
    assign cnt[t] = cnt_i[t*CW +: CW];
  end

  always_comb begin
    left = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      idx[t] = '0;
      fin[t] = policy_rr && (TW'(t) != rr_ptr);
      if (!fin[t]) left = left + NW'(cnt[t]);
    end
    ret_o = '0; sq_o = '0; cmt_o = '0;
    cause_o = CZ_NONE; blame_o = '0;
    stop = 1'b0; have = 1'b0; pick = '0; best = '0; cand = '0; e = 0;
    for (int s = 0; s < STEPS; s++) begin
      if (!stop) begin
        have = 1'b0; pick = '0; best = '0;
        if (policy_rr) begin
          pick = rr_ptr;
          have = idx[pick] < cnt[pick];
        end else begin
          for (int t = 0; t < NUM_THR; t++) begin
            if (!fin[t] && idx[t] < cnt[t]) begin
              cand = seq_i[(t*HEAD_D + int'(idx[t]))*SEQ_W +: SEQ_W];
              if (!have || cand < best) begin
                have = 1'b1; pick = TW'(t); best = cand;
              end
            end
          end
        end
        if (have) begin
          e = int'(pick)*HEAD_D + int'(idx[pick]);
          idx[pick] = idx[pick] + 1'b1;
          left = left - 1'b1;
          if (ok_i[e]) begin
            if (spec_i[e]) sq_o[e] = 1'b1;
            else begin
              ret_o[e] = 1'b1;
              cmt_o = cmt_o + 1'b1;
            end
            if (cmt_o == W_C) begin
              cause_o = CZ_BW; blame_o = pick; stop = 1'b1;
            end else if (left == '0) begin
              cause_o = CZ_EMPTY; blame_o = pick; stop = 1'b1;
            end
          end else begin
            if (stall_i[e] && cause_o == CZ_NONE) cause_o = CZ_SBUF;
            blame_o = pick;
            idx[pick] = cnt[pick];
          end
          if (idx[pick] == cnt[pick]) fin[pick] = 1'b1;
        end else if (policy_rr) fin[pick] = 1'b1;
        else stop = 1'b1;
        if (&fin) stop = 1'b1;
      end
    end
    if (cause_o == CZ_NONE) begin
      cause_o = (cmt_o == W_C) ? CZ_BW : CZ_EMPTY;
      blame_o = '0;
    end
  end
endmodule

// File: rtl/commit_sel.sv
module commit_sel
  import cmt_pkg::*;
#(
  parameter int NUM_THR  = 4,
  parameter int HEAD_D   = 4,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W    = 16,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CW = $clog2(HEAD_D + 1),
  localparam int MW = $clog2(COMMIT_W + 1),
  localparam int NE = NUM_THR * HEAD_D
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  policy_rr,
  input  logic                  sb_full,
  input  logic [NUM_THR*CW-1:0] hd_cnt,
  input  logic [NE-1:0]         hd_done,
  input  logic [NE-1:0]         hd_store,
  input  logic [NE-1:0]         hd_spec,
  input  logic [NE*SEQ_W-1:0]   hd_seq,
  output logic [NE-1:0]         retire_mask,
  output logic [NE-1:0]         squash_mask,
  output logic [MW-1:0]         retired_cnt,
  output logic [2:0]            end_cause,
  output logic [TW-1:0]         blame_tid
);
  logic [NE-1:0] ok, stall, ret_n, sq_n;
  logic [MW-1:0] cmt_n;
  cause_e        cause_n;
  logic [TW-1:0] blame_n, rr_ptr;
  logic          cap_en;

  assign cap_en = 1'b1;

  cmt_elig #(.NE(NE)) u_elig (
    .sb_full(sb_full), .done_i(hd_done), .store_i(hd_store),
    .ok_o(ok), .stall_o(stall)
  );

  cmt_rr_ptr #(.NUM_THR(NUM_THR)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(policy_rr), .ptr(rr_ptr)
  );

  cmt_pick #(.NUM_THR(NUM_THR), .HEAD_D(HEAD_D), .COMMIT_W(COMMIT_W),
             .SEQ_W(SEQ_W)) u_pick (
    .policy_rr(policy_rr), .rr_ptr(rr_ptr), .cnt_i(hd_cnt),
    .ok_i(ok), .stall_i(stall), .spec_i(hd_spec), .seq_i(hd_seq),
    .ret_o(ret_n), .sq_o(sq_n), .cmt_o(cmt_n), .cause_o(cause_n),
    .blame_o(blame_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_mask <= '0;
      squash_mask <= '0;
      retired_cnt <= '0;
      end_cause   <= CZ_NONE;
      blame_tid   <= '0;
    end else if (cap_en) begin
      retire_mask <= ret_n;
      squash_mask <= sq_n;
      retired_cnt <= cmt_n;
      end_cause   <= cause_n;
      blame_tid   <= blame_n;
    end
  end

  logic [NUM_THR-1:0] thr_busy;
  logic               rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= 1'b0;
    else        rr_q <= policy_rr;
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    logic [HEAD_D-1:0] used;
    assign used        = retire_mask[t*HEAD_D +: HEAD_D] | squash_mask[t*HEAD_D +: HEAD_D];
    assign thr_busy[t] = |used;
    // R10: handled entries form a prefix of the thread window
    a_r10_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      (used & (used + 1'b1)) == '0);
  end

  // R5: count never exceeds the width
  a_r5_cnt_max: assert property (@(posedge clk) disable iff (!rst_n)
    retired_cnt <= MW'(COMMIT_W));
  // R5: full width always reports bandwidth
  a_r5_bw_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retired_cnt == MW'(COMMIT_W) |-> end_cause == CZ_BW);
  // R4: no entry is both retired and squashed
  a_r4_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_mask & squash_mask) == '0);
  // R2: a round-robin result touches at most one thread
  a_r2_single_thr: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q |-> $onehot0(thr_busy));
  // R9: after the first captured cycle a cause is always reported
  a_r9_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> end_cause != CZ_NONE);
endmodule

// File: tb/tb_commit_sel.sv
module tb_commit_sel;
  localparam int NT = 2, D = 3, W = 2, SQW = 8;

  typedef struct packed {
    logic       sbf;
    logic [1:0] c0, c1;
    logic [5:0] dn, st, sp;
    logic [47:0] sq;
    logic [5:0] er, es;
    logic [1:0] ec;
    logic [2:0] ca;
    logic       eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0,2'd2,2'd2,6'b011011,6'b0,6'b0,48'h000302000401,6'b001001,6'b0,2'd2,3'd1,1'b1},
    '{1'b0,2'd1,2'd0,6'b000001,6'b0,6'b0,48'h000000000001,6'b000001,6'b0,2'd1,3'd2,1'b0},
    '{1'b0,2'd0,2'd0,6'b000000,6'b0,6'b0,48'h000000000000,6'b000000,6'b0,2'd0,3'd2,1'b0},
    '{1'b0,2'd3,2'd0,6'b000111,6'b0,6'b000011,48'h000000030201,6'b000100,6'b000011,2'd1,3'd2,1'b0},
    '{1'b1,2'd1,2'd2,6'b011001,6'b001000,6'b0,48'h000605000007,6'b000001,6'b0,2'd1,3'd3,1'b1},
    '{1'b0,2'd2,2'd2,6'b011010,6'b0,6'b0,48'h000403000201,6'b011000,6'b0,2'd2,3'd1,1'b1},
    '{1'b0,2'd1,2'd1,6'b001001,6'b000001,6'b0,48'h000003000009,6'b001001,6'b0,2'd2,3'd1,1'b0},
    '{1'b0,2'd2,2'd2,6'b011011,6'b0,6'b0,48'h000504000804,6'b001001,6'b0,2'd2,3'd1,1'b1},
    '{1'b0,2'd0,2'd1,6'b000000,6'b0,6'b0,48'h000001000000,6'b000000,6'b0,2'd0,3'd2,1'b0},
    '{1'b0,2'd3,2'd0,6'b000111,6'b0,6'b000001,48'h000000030201,6'b000110,6'b000001,2'd2,3'd1,1'b0},
    '{1'b0,2'd1,2'd0,6'b000000,6'b0,6'b000001,48'h000000000001,6'b000000,6'b0,2'd0,3'd2,1'b0},
    '{1'b1,2'd1,2'd0,6'b000000,6'b000001,6'b0,48'h000000000001,6'b000000,6'b0,2'd0,3'd2,1'b0}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1/R5 oldest merge";
      1: return "R6 last entry";
      2: return "R8 empty windows";
      3: return "R4 squash";
      4: return "R3/R7 store stall";
      5: return "R7 skip thread";
      6: return "R3 store free buffer";
      7: return "R1 tie to low thread";
      8: return "R8 default blame";
      9: return "R4/R5 squash outside width";
      10: return "R3 spec incomplete";
      default: return "R3 incomplete store";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic policy_rr = 1'b0, sb_full = 1'b0;
  logic [3:0]  hd_cnt = '0;
  logic [5:0]  hd_done = '0, hd_store = '0, hd_spec = '0;
  logic [47:0] hd_seq = '0;
  logic [5:0]  retire_mask, squash_mask;
  logic [1:0]  retired_cnt;
  logic [2:0]  end_cause;
  logic        blame_tid;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  commit_sel #(.NUM_THR(NT), .HEAD_D(D), .COMMIT_W(W), .SEQ_W(SQW)) dut (
    .clk(clk), .rst_n(rst_n), .policy_rr(policy_rr), .sb_full(sb_full),
    .hd_cnt(hd_cnt), .hd_done(hd_done), .hd_store(hd_store), .hd_spec(hd_spec),
    .hd_seq(hd_seq), .retire_mask(retire_mask), .squash_mask(squash_mask),
    .retired_cnt(retired_cnt), .end_cause(end_cause), .blame_tid(blame_tid)
  );

  task automatic check(string tag, logic [5:0] er, logic [5:0] es, logic [1:0] ec,
                       logic [2:0] ca, logic eb);
    n_chk++;
    if (retire_mask !== er || squash_mask !== es || retired_cnt !== ec ||
        end_cause !== ca || blame_tid !== eb) begin
      n_bad++;
      $display("FAIL %s: got ret=%b sq=%b cnt=%0d cause=%0d blame=%0d exp ret=%b sq=%b cnt=%0d cause=%0d blame=%0d",
               tag, retire_mask, squash_mask, retired_cnt, end_cause, blame_tid,
               er, es, ec, ca, eb);
    end
  endtask

  task automatic drive(vec_t v, logic rr);
    policy_rr = rr; sb_full = v.sbf; hd_cnt = {v.c1, v.c0};
    hd_done = v.dn; hd_store = v.st; hd_spec = v.sp; hd_seq = v.sq;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // two threads, one completed entry each, seq 1 and 2
  localparam vec_t RRV = '{1'b0,2'd1,2'd1,6'b001001,6'b0,6'b0,48'h000002000001,
                           6'b0,6'b0,2'd0,3'd0,1'b0};
  localparam vec_t RRE = '{1'b0,2'd1,2'd0,6'b000001,6'b0,6'b0,48'h000000000001,
                           6'b0,6'b0,2'd0,3'd0,1'b0};

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset state", 6'b0, 6'b0, 2'd0, 3'd0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b0);
      check(vtag(i), VEC[i].er, VEC[i].es, VEC[i].ec, VEC[i].ca, VEC[i].eb);
    end
    // R2: pointer still 0 after oldest-first cycles, then alternates
    drive(RRV, 1'b1); check("R2 rr thread0", 6'b000001, 6'b0, 2'd1, 3'd2, 1'b0);
    drive(RRV, 1'b1); check("R2 rr thread1", 6'b001000, 6'b0, 2'd1, 3'd2, 1'b1);
    drive(RRV, 1'b1); check("R2 rr wrap", 6'b000001, 6'b0, 2'd1, 3'd2, 1'b0);
    drive(RRV, 1'b0); check("R1 oldest both", 6'b001001, 6'b0, 2'd2, 3'd1, 1'b1);
    drive(RRV, 1'b1); check("R2 rr hold under oldest", 6'b001000, 6'b0, 2'd1, 3'd2, 1'b1);
    // pointer now 0: go to 1, then empty pointer thread
    drive(RRV, 1'b1); check("R2 rr thread0 again", 6'b000001, 6'b0, 2'd1, 3'd2, 1'b0);
    drive(RRE, 1'b1); check("R2 rr empty thread1", 6'b0, 6'b0, 2'd0, 3'd2, 1'b0);
    // pointer back to 0, move to 1, then reset
    drive(RRV, 1'b1);
    policy_rr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears outputs", 6'b0, 6'b0, 2'd0, 3'd0, 1'b0);
    rst_n = 1'b1;
    drive(RRV, 1'b1); check("R9 reset clears pointer", 6'b000001, 6'b0, 2'd1, 3'd2, 1'b0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang exp completion");
    finish_run();
  end
endmodule